// File: doc/BRIEF.md
# Fixed-OR Product Array With Output Feedback

This block is a small programmable sum-of-products array. Only the AND plane can be programmed. Each output section owns its own group of product terms, and a fixed OR gate combines that group. No product line is shared between sections. A section's output is also offered as a literal to the AND plane of every section with a higher index. A function that needs more products than one section holds is therefore split: part of it is built in a lower section, and that output is reused through feedback.

The default build has four primary inputs, four outputs and three products per section. A parameter widens each section to four products. The AND-plane fuses are loaded one product at a time through a synchronous write port. A synchronous reset clears every fuse. The outputs are registered, so a change at the inputs appears after one clock edge.

Top module: `pal_feedback_array`

## Requirements
- R1: Literal index i (0 to N_IN-1) is pin[i]. Literal N_IN+j is the current-cycle value of output j. A fuse word is {complement mask, true mask}, each NLIT = N_IN+N_OUT bits wide. A set true bit i connects literal i, and a set complement bit i connects its inverse. A product is the AND of its connected literals.
- R2: A product with no effective connection evaluates to 0. A section whose fuses are all clear drives 0.
- R3: Output k is the OR of the N_PT products of section k only. Programming one section does not change another section's output, except through feedback literals.
- R4: Section k may use only the feedback of outputs 0..k-1. Connection bits to feedback of output k or higher, in either polarity, are ignored.
- R5: Outputs are registered. q_out after clock edge e reflects pin as sampled at edge e. Between edges it holds.
- R6: When cfg_we is high at edge e, the word cfg_data is stored for section cfg_sec and product cfg_pt. The outputs first reflect it after edge e+1. No other fuse changes.
- R7: A write with cfg_sec >= N_OUT or cfg_pt >= N_PT changes no fuse.
- R8: Synchronous active-high reset clears all fuses and drives q_out to 0.
- R9: With W = m(2,12,13) in section 0, and Z = W + two products in section 3 reusing W through feedback, Z equals m(1,2,8,12,13) over all 16 input values. The minterm index is pin (A=pin[3], D=pin[0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin | input | N_IN | Primary inputs (literal indices 0..N_IN-1) |
| cfg_we | input | 1 | Fuse write strobe |
| cfg_sec | input | SECW | Section index of the write |
| cfg_pt | input | PTW | Product index within the section |
| cfg_data | input | 2*NLIT | Fuse word {complement mask, true mask} |
| q_out | output | N_OUT | Registered section outputs, bit k = section k |

## Verification
Several properties are checked on every cycle. A write to a valid index lands in exactly that fuse word. Fuses stay unchanged when no valid write occurs. A section with cleared fuses drives 0 on the next cycle. The outputs hold when the inputs and the fuses have been steady. The truth of the programmed functions, the feedback reuse, the masking of higher-index feedback, the one-cycle latency and the write-to-output delay can only be shown by the bench, which sweeps all sixteen input values against minterm masks.

// File: rtl/pal_fb_pkg.sv
package pal_fb_pkg;

  // Literals a section may connect: primary inputs plus feedback of lower sections.
  function automatic logic [63:0] allow_mask(int nin, int k);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < nin + k) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pal_fuse_bank.sv
module pal_fuse_bank #(
  parameter int NSEC = 4,
  parameter int NPT  = 3,
  parameter int FW   = 16,
  parameter int SECW = 2,
  parameter int PTW  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SECW-1:0]          sec,
  input  logic [PTW-1:0]           pt,
  input  logic [FW-1:0]            data,
  output logic [NSEC*NPT*FW-1:0]   fuse_flat
);
  localparam int NW = NSEC * NPT;
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;

  logic [FW-1:0] mem [NW];
  logic          wr_ok;
  logic [IW-1:0] wr_idx;

  always_comb begin
    wr_ok  = we && (int'(sec) < NSEC) && (int'(pt) < NPT);
    wr_idx = IW'(int'(sec) * NPT + int'(pt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_idx] <= data;
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_out
    assign fuse_flat[i*FW +: FW] = mem[i];
  end

endmodule

// File: rtl/pal_term.sv
module pal_term #(
  parameter int NLIT = 8
) (
  input  logic [NLIT-1:0]   lits,
  input  logic [2*NLIT-1:0] fuse,
  input  logic [NLIT-1:0]   allow,
  output logic              term
);
  logic [NLIT-1:0] eff_t, eff_c;
  logic            used, hit;

  always_comb begin
    eff_t = fuse[NLIT-1:0] & allow;
    eff_c = fuse[2*NLIT-1:NLIT] & allow;
    used  = |(eff_t | eff_c);
    hit   = &((~eff_t | lits) & (~eff_c | ~lits));
    term  = used & hit;
  end

endmodule

// File: rtl/pal_section.sv
module pal_section #(
  parameter int NLIT = 8,
  parameter int NPT  = 3,
  parameter int N_IN = 4,
  parameter int K    = 0
) (
  input  logic [NLIT-1:0]       lits,
  input  logic [NPT*2*NLIT-1:0] fuses,
  output logic                  sum
);
  localparam int FW = 2 * NLIT;
  localparam logic [63:0]     FULL  = pal_fb_pkg::allow_mask(N_IN, K);
  localparam logic [NLIT-1:0] ALLOW = FULL[NLIT-1:0];

  logic [NPT-1:0] terms;

  for (genvar p = 0; p < NPT; p++) begin : g_pt
    pal_term #(.NLIT(NLIT)) u_term (
      .lits  (lits),
      .fuse  (fuses[p*FW +: FW]),
      .allow (ALLOW),
      .term  (terms[p])
    );
  end

  assign sum = |terms;

endmodule

// File: rtl/pal_feedback_array.sv
module pal_feedback_array #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_PT  = 3,
  localparam int NLIT = N_IN + N_OUT,
  localparam int FW   = 2 * NLIT,
  localparam int SECW = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int PTW  = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  pin,
  input  logic             cfg_we,
  input  logic [SECW-1:0]  cfg_sec,
  input  logic [PTW-1:0]   cfg_pt,
  input  logic [FW-1:0]    cfg_data,
  output logic [N_OUT-1:0] q_out
);
  localparam int SFW = N_PT * FW;

  logic [N_OUT*SFW-1:0] fuse_flat;
  logic [N_OUT-1:0]     comb_q;

  pal_fuse_bank #(
    .NSEC(N_OUT), .NPT(N_PT), .FW(FW), .SECW(SECW), .PTW(PTW)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .sec       (cfg_sec),
    .pt        (cfg_pt),
    .data      (cfg_data),
    .fuse_flat (fuse_flat)
  );

  // Literal chain: each stage adds its own output for the stages above it.
  for (genvar k = 0; k < N_OUT; k++) begin : g_sec
    logic [NLIT-1:0] lit_in, lit_out;
    logic            sum;

    if (k == 0) begin : g_first
      assign lit_in = {{N_OUT{1'b0}}, pin};
    end else begin : g_next
      assign lit_in = g_sec[k-1].lit_out;
    end

    pal_section #(.NLIT(NLIT), .NPT(N_PT), .N_IN(N_IN), .K(k)) u_sec (
      .lits  (lit_in),
      .fuses (fuse_flat[k*SFW +: SFW]),
      .sum   (sum)
    );

    always_comb begin
      lit_out = lit_in;
      lit_out[N_IN+k] = sum;
    end

    assign comb_q[k] = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) q_out <= '0;
    else     q_out <= comb_q;
  end

endmodule

// File: rtl/pal_feedback_chk.sv
module pal_feedback_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_PT  = 3,
  localparam int NLIT = N_IN + N_OUT,
  localparam int FW   = 2 * NLIT,
  localparam int SECW = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int PTW  = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_IN-1:0]           pin,
  input logic                      cfg_we,
  input logic [SECW-1:0]           cfg_sec,
  input logic [PTW-1:0]            cfg_pt,
  input logic [FW-1:0]             cfg_data,
  input logic [N_OUT-1:0]          q_out,
  input logic [N_OUT*N_PT*FW-1:0]  fuse_flat
);
  localparam int SFW = N_PT * FW;

  logic          wr_valid;
  logic          wr_pend_q;
  int            wr_idx_q;
  logic [FW-1:0] wr_data_q;

  assign wr_valid = cfg_we && (int'(cfg_sec) < N_OUT) && (int'(cfg_pt) < N_PT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend_q <= 1'b0;
      wr_idx_q  <= 0;
      wr_data_q <= '0;
    end else begin
      wr_pend_q <= wr_valid;
      wr_idx_q  <= int'(cfg_sec) * N_PT + int'(cfg_pt);
      wr_data_q <= cfg_data;
    end
  end

  // R6
  cfg_land_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pend_q |-> (fuse_flat[wr_idx_q*FW +: FW] == wr_data_q));

  // R7
  cfg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(fuse_flat));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && $stable(pin)) |=> $stable(q_out));

  for (genvar k = 0; k < N_OUT; k++) begin : g_empty
    // R2
    empty_sec_chk: assert property (@(posedge clk) disable iff (rst)
      (fuse_flat[k*SFW +: SFW] == '0) |=> (q_out[k] == 1'b0));
  end

endmodule

bind pal_feedback_array pal_feedback_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pin       (pin),
  .cfg_we    (cfg_we),
  .cfg_sec   (cfg_sec),
  .cfg_pt    (cfg_pt),
  .cfg_data  (cfg_data),
  .q_out     (q_out),
  .fuse_flat (fuse_flat)
);

// File: tb/sim_pal_feedback_array.sv
`timescale 1ns/1ps
module sim_pal_feedback_array;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pin = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sec = '0;
  logic [1:0]  cfg_pt = '0;
  logic [15:0] cfg_data = '0;
  logic [3:0]  q_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pal_feedback_array u0 (
    .clk(clk), .rst(rst), .pin(pin), .cfg_we(cfg_we), .cfg_sec(cfg_sec),
    .cfg_pt(cfg_pt), .cfg_data(cfg_data), .q_out(q_out)
  );

  // Minterm masks, bit v set when the function is 1 for pin == v.
  localparam logic [15:0] MW = 16'h3004;
  localparam logic [15:0] MX = 16'hFF80;
  localparam logic [15:0] MY = 16'hCFFB;
  localparam logic [15:0] MZ = 16'h3106;

  function automatic logic [3:0] expect_q(int v, logic [15:0] mw, logic [15:0] mx,
                                          logic [15:0] my, logic [15:0] mz);
    return {mz[v], my[v], mx[v], mw[v]};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(int sec, int pt, logic [7:0] cmask, logic [7:0] tmask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sec = 2'(sec); cfg_pt = 2'(pt); cfg_data = {cmask, tmask};
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic sweep(string tag, logic [15:0] mw, logic [15:0] mx,
                       logic [15:0] my, logic [15:0] mz);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); pin = 4'(v);
      @(posedge clk);
      @(negedge clk);
      check(tag, q_out, expect_q(v, mw, mx, my, mz));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R8 reset output", q_out, 4'b0000);
    @(negedge clk) rst = 1'b0;

    // R2: nothing programmed, all outputs stay 0
    sweep("R2 empty array", 16'h0, 16'h0, 16'h0, 16'h0);

    // Section 0: W; third product connects only feedback literals (R4 masking)
    wr(0, 0, 8'h0D, 8'h02);
    wr(0, 1, 8'h02, 8'h0C);
    wr(0, 2, 8'h90, 8'h00);
    sweep("R3 R4 W only", MW, 16'h0, 16'h0, 16'h0);

    // X = A + BCD, Y = ~W via feedback, Z = W + A'B'C'D + AC'D'
    wr(1, 0, 8'h00, 8'h08);
    wr(1, 1, 8'h00, 8'h07);
    wr(2, 0, 8'h10, 8'h00);
    wr(3, 0, 8'h00, 8'h10);
    wr(3, 1, 8'h0E, 8'h01);
    wr(3, 2, 8'h03, 8'h08);
    sweep("R1 R9 full array", MW, MX, MY, MZ);

    // R5: one-cycle latency
    @(negedge clk) pin = 4'd2;
    @(posedge clk); @(negedge clk);
    pin = 4'd7;
    #1 check("R5 before edge", q_out, expect_q(2, MW, MX, MY, MZ));
    @(posedge clk);
    #1 check("R5 after edge", q_out, expect_q(7, MW, MX, MY, MZ));

    // R6: write-to-output timing, X product 0 becomes ~A
    @(negedge clk) pin = 4'd0;
    @(posedge clk); @(negedge clk);
    check("R6 baseline", q_out, expect_q(0, MW, MX, MY, MZ));
    cfg_we = 1'b1; cfg_sec = 2'd1; cfg_pt = 2'd0; cfg_data = {8'h08, 8'h00};
    @(posedge clk);
    #1 cfg_we = 1'b0;
    check("R6 write edge", q_out, expect_q(0, MW, MX, MY, MZ));
    @(posedge clk);
    #1 check("R6 next edge", q_out, expect_q(0, MW, 16'hFFFF, MY, MZ));
    wr(1, 0, 8'h00, 8'h08);

    // R7: product index 3 is out of range for three products
    wr(0, 3, 8'h00, 8'h00);
    wr(0, 3, 8'hFF, 8'h00);
    wr(3, 3, 8'h00, 8'h01);
    sweep("R7 ignored write", MW, MX, MY, MZ);

    // R8: reset clears fuses and outputs
    @(negedge clk) rst = 1'b1; pin = 4'd12;
    @(posedge clk);
    #1 check("R8 mid reset output", q_out, 4'b0000);
    @(negedge clk) rst = 1'b0;
    sweep("R8 fuses cleared", 16'h0, 16'h0, 16'h0, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule